// File: doc/BRIEF.md
# SAR Converter Control Sequencer

This block runs an 8-bit successive-approximation conversion around an external comparator and trial DAC. Software writes a control byte that turns the module on, picks one of four analog channels, picks a conversion-clock source and sets a go/busy bit. The sequencer then spends one and a half conversion-clock periods letting the input settle and decides the code one bit per conversion-clock period, most significant bit first. A whole conversion lasts 9.5 conversion-clock periods. At the end the code is loaded into the result register, go/busy drops and a done flag rises.

The conversion clock is the system clock divided by 2, 8 or 32, or a free-running RC clock whose half-period edges arrive as pulses on `rc_edge`. While `sleep_i` is high the system oscillator is taken as stopped, so a conversion timed from it freezes. A conversion timed from the RC clock keeps running in sleep. When the RC clock is selected, the start is held back one instruction cycle so that the processor can enter sleep first. A separate 3-bit configuration code decides which of the four port pins are analog inputs.

The sequencer has four states. `ST_IDLE` waits for an accepted start. `ST_RC_HOLD` is the one-instruction-cycle delay before an RC-clocked conversion. `ST_SETTLE` lasts three half periods. `ST_TRIAL` holds the eight bit decisions. The transitions are:
- idle to hold, on a start with the RC source;
- idle to settle, on a start with a divided source;
- hold to settle, after the last hold cycle;
- settle to trial, on the third half period;
- trial to idle, on the decision for bit 0;
- any active state to idle, on abort.

Top module: `sar_seq_top`

## Requirements
- R1: After reset these outputs are all zero: `ctrl_q`, `result`, `done_flag` and `dac_code`. `analog_en` is 4'b1111.
- R2: The control byte has these fields. Bit 0 is module on. Bit 2 is go/busy. Bits 4:3 are the channel. Bits 7:6 select the clock: 00 is sysclk/2, 01 is sysclk/8, 10 is sysclk/32 and 11 is the RC clock. `ctrl_q` reads the fields back, with bits 1 and 5 read as 0. `chan_sel` follows bits 4:3.
- R3: A control write with bit 0 = 1 and bit 2 = 1, made while idle, starts a conversion. The same edge sets go/busy and clears `done_flag`.
- R4: Bits are decided from bit 7 down to bit 0. The trial code drives `dac_code`, and a bit is kept when `cmp_i` = 1. The result equals the largest code not above the input of the selected channel.
- R5: A conversion with a divided source completes 19 half periods after the start edge. That is 19, 76 and 304 system clocks for /2, /8 and /32.
- R6: On completion, a single edge loads `result`, clears go/busy (`ctrl_q[2]`) and sets `done_flag`.
- R7: With the RC source, settling begins 4 system clocks (one instruction cycle) after the start edge. Each `rc_edge` pulse after that is one half period, so completion comes 4 + 19 clocks after the start when `rc_edge` is held high.
- R8: While `sleep_i` = 1, a conversion on a divided source does not advance, and it resumes when `sleep_i` falls. An RC-source conversion is not slowed by sleep.
- R9: A control write with bit 0 = 0 during a conversion aborts it. Go/busy clears, `result` keeps its old value and `done_flag` stays 0.
- R10: A control write that sets go/busy with bit 0 = 0 is ignored. Go/busy stays 0, and no conversion or result change follows.
- R11: The configuration code `c` (`wr_data[2:0]` with `wr_cfg`) makes pin i analog when c + i < 4. Code 0 gives 4'b1111 and codes 4 to 7 give 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_ctrl | input | 1 | Write strobe for the control byte |
| wr_cfg | input | 1 | Write strobe for the pin configuration code |
| wr_data | input | 8 | Write data shared by both strobes |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| sleep_i | input | 1 | Processor sleep indication |
| rc_edge | input | 1 | One pulse per RC-clock half period |
| dac_code | output | 8 | Trial code for the DAC |
| chan_sel | output | 2 | Selected analog channel |
| ctrl_q | output | 8 | Control byte readback |
| result | output | 8 | Last completed conversion result |
| done_flag | output | 1 | Conversion-complete interrupt flag |
| analog_en | output | 4 | Per-pin analog enable from the configuration code |

## Verification
A start is taken at the first clock edge after the write is driven. Go/busy and the cleared done flag are checked at the following negative edge. The completion time is measured by counting clock edges after the start edge until `done_flag` is seen at a negative edge. That count must equal exactly 19 times the half period for the divided sources, and 4 + 19 for the RC source, so a delay that is one cycle early or late fails. Readback, abort and ignored writes take effect at the edge after the write and are checked on the next negative edge. The checks that nothing happens then watch `done_flag` and `result` for longer than a full conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RC_HOLD,
        ST_SETTLE,
        ST_TRIAL
    } sar_state_t;

    typedef enum logic [1:0] {
        CK_DIV_A = 2'b00,
        CK_DIV_B = 2'b01,
        CK_DIV_C = 2'b10,
        CK_RC    = 2'b11
    } ck_src_t;

    // control byte field positions
    localparam int CTL_EN   = 0;
    localparam int CTL_GO   = 2;
    localparam int CTL_CH_L = 3;
    localparam int CTL_CK_L = 6;

endpackage

// File: rtl/sar_half_tick.sv
module sar_half_tick
    import sar_seq_pkg::*;
#(
    parameter int DIV_A = 2,
    parameter int DIV_B = 8,
    parameter int DIV_C = 32
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    run,
    input  ck_src_t src,
    input  logic    sleep_i,
    input  logic    rc_edge,
    output logic    half_tick
);
    localparam int CW = $clog2(DIV_C / 2) + 1;
    localparam logic [CW-1:0] LIM_A = CW'(DIV_A / 2 - 1);
    localparam logic [CW-1:0] LIM_B = CW'(DIV_B / 2 - 1);
    localparam logic [CW-1:0] LIM_C = CW'(DIV_C / 2 - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          sys_tick;

    always_comb begin
        unique case (src)
            CK_DIV_A: lim = LIM_A;
            CK_DIV_B: lim = LIM_B;
            CK_DIV_C: lim = LIM_C;
            CK_RC:    lim = LIM_A;
        endcase
    end

    assign sys_tick  = run && !sleep_i && (cnt == lim);
    assign half_tick = (src == CK_RC) ? (run && rc_edge) : sys_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!sleep_i) begin
            cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         decide,
    input  logic         cmp_i,
    output logic [W-1:0] acc,
    output logic [W-1:0] trial,
    output logic         last
);
    localparam int IW = $clog2(W);

    logic [IW-1:0] idx;

    assign last  = (idx == '0);
    assign trial = acc | (W'(1) << idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            idx <= IW'(W - 1);
        end else if (clear) begin
            acc <= '0;
            idx <= IW'(W - 1);
        end else if (decide) begin
            acc[idx] <= cmp_i;
            if (!last) idx <= idx - 1'b1;
        end
    end
endmodule

// File: rtl/sar_pin_map.sv
module sar_pin_map #(
    parameter int CFG_W = 3,
    parameter int NPINS = 4
) (
    input  logic [CFG_W-1:0] code,
    output logic [NPINS-1:0] analog_en
);
    localparam int SW = CFG_W + $clog2(NPINS) + 1;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign analog_en[i] = (SW'(code) + SW'(i)) < SW'(NPINS);
    end
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int W          = 8,
    parameter int CH_W       = 2,
    parameter int CFG_W      = 3,
    parameter int NPINS      = 4,
    parameter int INSTR_CLKS = 4,
    parameter int DIV_A      = 2,
    parameter int DIV_B      = 8,
    parameter int DIV_C      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_cfg,
    input  logic [7:0]       wr_data,
    input  logic             cmp_i,
    input  logic             sleep_i,
    input  logic             rc_edge,
    output logic [W-1:0]     dac_code,
    output logic [CH_W-1:0]  chan_sel,
    output logic [7:0]       ctrl_q,
    output logic [W-1:0]     result,
    output logic             done_flag,
    output logic [NPINS-1:0] analog_en
);
    localparam int HW = $clog2(INSTR_CLKS);
    localparam logic [HW-1:0] HOLD_LAST = HW'(INSTR_CLKS - 1);
    localparam int PW = 2;
    localparam logic [PW-1:0] SETTLE_LAST = PW'(2);

    sar_state_t        state_q, state_d;
    ck_src_t           src_q;
    ck_src_t           wr_src;
    logic              en_q, go_q;
    logic [CH_W-1:0]   ch_q;
    ck_src_t           cks_q;
    logic [CFG_W-1:0]  cfg_q;
    logic [W-1:0]      result_q;
    logic              done_q;
    logic [HW-1:0]     wcnt;
    logic [PW-1:0]     phc;
    logic              run, half_tick;
    logic              start_req, abort, decide, finish;
    logic [W-1:0]      acc, trial;
    logic              last;
    logic              unused_bits;

    assign unused_bits = ^{wr_data[5], wr_data[1]};
    assign wr_src      = ck_src_t'(wr_data[CTL_CK_L +: 2]);

    assign start_req = wr_ctrl && wr_data[CTL_GO] && wr_data[CTL_EN] && (state_q == ST_IDLE);
    assign abort     = wr_ctrl && !wr_data[CTL_EN] && (state_q != ST_IDLE);
    assign run       = (state_q == ST_SETTLE) || (state_q == ST_TRIAL);
    assign decide    = (state_q == ST_TRIAL) && half_tick && phc[0];
    assign finish    = decide && last;

    sar_half_tick #(
        .DIV_A (DIV_A),
        .DIV_B (DIV_B),
        .DIV_C (DIV_C)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .src       (src_q),
        .sleep_i   (sleep_i),
        .rc_edge   (rc_edge),
        .half_tick (half_tick)
    );

    sar_approx #(.W(W)) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start_req),
        .decide (decide),
        .cmp_i  (cmp_i),
        .acc    (acc),
        .trial  (trial),
        .last   (last)
    );

    sar_pin_map #(.CFG_W(CFG_W), .NPINS(NPINS)) u_pins (
        .code      (cfg_q),
        .analog_en (analog_en)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) state_d = (wr_src == CK_RC) ? ST_RC_HOLD : ST_SETTLE;
            end
            ST_RC_HOLD: begin
                if (wcnt == HOLD_LAST) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (half_tick && phc == SETTLE_LAST) state_d = ST_TRIAL;
            end
            ST_TRIAL: begin
                if (finish) state_d = ST_IDLE;
            end
        endcase
        if (abort) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // phase counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt <= '0;
            phc  <= '0;
        end else begin
            wcnt <= (state_q == ST_RC_HOLD && state_d == ST_RC_HOLD) ? wcnt + 1'b1 : '0;
            if (state_d != state_q) begin
                phc <= '0;
            end else if (half_tick && run) begin
                phc <= (state_q == ST_TRIAL) ? {1'b0, ~phc[0]} : phc + 1'b1;
            end
        end
    end

    // registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            go_q     <= 1'b0;
            ch_q     <= '0;
            cks_q    <= CK_DIV_A;
            src_q    <= CK_DIV_A;
            cfg_q    <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en_q  <= wr_data[CTL_EN];
                ch_q  <= wr_data[CTL_CH_L +: CH_W];
                cks_q <= wr_src;
            end
            if (wr_cfg) cfg_q <= wr_data[CFG_W-1:0];
            if (start_req) begin
                go_q   <= 1'b1;
                done_q <= 1'b0;
                src_q  <= wr_src;
            end else if (abort) begin
                go_q <= 1'b0;
            end else if (finish) begin
                go_q     <= 1'b0;
                done_q   <= 1'b1;
                result_q <= acc | W'(cmp_i);
            end
        end
    end

    assign dac_code  = (state_q == ST_TRIAL) ? trial : acc;
    assign chan_sel  = ch_q;
    assign result    = result_q;
    assign done_flag = done_q;
    assign ctrl_q    = {cks_q, 1'b0, ch_q, go_q, 1'b0, en_q};
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk
    import sar_seq_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_ctrl,
    input logic [7:0]   wr_data,
    input logic         sleep_i,
    input logic [7:0]   ctrl_q,
    input logic [W-1:0] result,
    input logic [W-1:0] dac_code,
    input logic         done_flag,
    input sar_state_t   state_q,
    input ck_src_t      src_q
);
    p_go_drops_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> !ctrl_q[CTL_GO]);

    p_result_only_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $rose(done_flag));

    p_abort_clears_go_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wr_data[CTL_EN] && ctrl_q[CTL_GO]) |=> (!ctrl_q[CTL_GO] && !done_flag));

    p_go_ignored_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wr_data[CTL_GO] && !wr_data[CTL_EN] && !ctrl_q[CTL_GO]) |=> !ctrl_q[CTL_GO]);

    p_sleep_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && !wr_ctrl && src_q != CK_RC &&
         (state_q == ST_SETTLE || state_q == ST_TRIAL))
        |=> ($stable(dac_code) && !$rose(done_flag)));

    p_start_clears_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q[CTL_GO]) |-> !done_flag);
endmodule

bind sar_seq_top sar_seq_chk #(.W(W)) u_sar_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr_ctrl),
    .wr_data   (wr_data),
    .sleep_i   (sleep_i),
    .ctrl_q    (ctrl_q),
    .result    (result),
    .dac_code  (dac_code),
    .done_flag (done_flag),
    .state_q   (state_q),
    .src_q     (src_q)
);

// File: tb/test_sar_seq_top.sv
module test_sar_seq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_ctrl = 1'b0, wr_cfg = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sleep_i = 1'b0, rc_edge = 1'b0;
    logic       cmp_i;
    logic [7:0] dac_code, ctrl_q, result;
    logic [1:0] chan_sel;
    logic       done_flag;
    logic [3:0] analog_en;
    logic [7:0] vin [4];

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    // analog front end model
    assign cmp_i = (vin[chan_sel] >= dac_code);

    sar_seq_top i_sar_seq_top (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_cfg(wr_cfg),
        .wr_data(wr_data), .cmp_i(cmp_i), .sleep_i(sleep_i), .rc_edge(rc_edge),
        .dac_code(dac_code), .chan_sel(chan_sel), .ctrl_q(ctrl_q),
        .result(result), .done_flag(done_flag), .analog_en(analog_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // drive one control write; returns after the edge that samples it
    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk);
        wr_data = v; wr_ctrl = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_ctrl = 1'b0;
    endtask

    // count edges after the start edge until done is seen
    task automatic wait_done(output int n);
        n = 0;
        while (!done_flag && n < 2000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset;
        chk(ctrl_q == 8'h00, "R1 ctrl", ctrl_q, 0);
        chk(result == 8'h00 && done_flag == 1'b0, "R1 result/done", {done_flag, result}, 0);
        chk(dac_code == 8'h00, "R1 dac", dac_code, 0);
        chk(analog_en == 4'b1111, "R1 analog_en", analog_en, 4'hf);
    endtask

    task automatic t_readback;
        wr_ctl(8'hFA);
        chk(ctrl_q == 8'hD8, "R2 readback", ctrl_q, 8'hD8);
        chk(chan_sel == 2'd3, "R2 chan_sel", chan_sel, 3);
    endtask

    task automatic t_convert(input logic [1:0] cks, input logic [1:0] ch,
                             input logic [7:0] v, input int exp_n, input string tag);
        int n;
        vin[ch] = v;
        wr_ctl({cks, 1'b0, ch, 1'b1, 1'b0, 1'b1});
        chk(ctrl_q[2] == 1'b1 && done_flag == 1'b0, "R3 start", {ctrl_q[2], done_flag}, 2);
        wait_done(n);
        chk(n == exp_n, tag, n, exp_n);
        chk(result == v, "R4 result", result, v);
        chk(ctrl_q[2] == 1'b0 && done_flag == 1'b1, "R6 done/go", {ctrl_q[2], done_flag}, 1);
    endtask

    task automatic t_sleep;
        int n;
        bit held = 1'b1;
        vin[1] = 8'h5C;
        sleep_i = 1'b1;
        wr_ctl(8'b00_0_01_1_0_1);
        repeat (30) begin
            @(posedge clk); @(negedge clk);
            if (done_flag || !ctrl_q[2]) held = 1'b0;
        end
        chk(held, "R8 frozen in sleep", held, 1);
        sleep_i = 1'b0;
        wait_done(n);
        chk(n == 19, "R8 resume", n, 19);
        chk(result == 8'h5C, "R8 result", result, 8'h5C);
    endtask

    task automatic t_rc;
        int n;
        vin[2] = 8'hA7;
        sleep_i = 1'b1;
        rc_edge = 1'b1;
        wr_ctl(8'b11_0_10_1_0_1);
        wait_done(n);
        chk(n == 23, "R7 rc delay", n, 23);
        chk(result == 8'hA7, "R7 rc result", result, 8'hA7);
        rc_edge = 1'b0;
        sleep_i = 1'b0;
    endtask

    task automatic t_abort;
        logic [7:0] prev;
        bit quiet = 1'b1;
        prev = result;
        vin[0] = 8'h11;
        wr_ctl(8'b01_0_00_1_0_1);
        repeat (30) @(negedge clk);
        wr_ctl(8'b01_0_00_0_0_0);
        chk(ctrl_q[2] == 1'b0, "R9 go cleared", ctrl_q[2], 0);
        repeat (400) begin
            @(negedge clk);
            if (done_flag || result != prev) quiet = 1'b0;
        end
        chk(quiet, "R9 no result", result, prev);
    endtask

    task automatic t_ignored;
        logic [7:0] prev;
        bit quiet = 1'b1;
        prev = result;
        vin[0] = 8'h22;
        wr_ctl(8'h04);
        chk(ctrl_q[2] == 1'b0, "R10 go ignored", ctrl_q[2], 0);
        repeat (100) begin
            @(negedge clk);
            if (done_flag || ctrl_q[2] || result != prev) quiet = 1'b0;
        end
        chk(quiet, "R10 no conversion", result, prev);
    endtask

    task automatic t_pins;
        for (int c = 0; c < 8; c++) begin
            logic [3:0] e;
            e = (c >= 4) ? 4'b0000 : (4'b1111 >> c);
            @(negedge clk);
            wr_data = 8'(c); wr_cfg = 1'b1;
            @(negedge clk);
            wr_cfg = 1'b0;
            chk(analog_en == e, "R11 pin map", analog_en, e);
        end
    endtask

    initial begin
        vin[0] = 8'h00; vin[1] = 8'h00; vin[2] = 8'h00; vin[3] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_convert(2'b00, 2'd0, 8'h96, 19,  "R5 div2 latency");
        t_convert(2'b01, 2'd3, 8'hFF, 76,  "R5 div8 latency");
        t_convert(2'b10, 2'd1, 8'h00, 304, "R5 div32 latency");
        t_convert(2'b00, 2'd2, 8'h01, 19,  "R5 div2 latency");
        t_sleep();
        t_rc();
        t_abort();
        t_ignored();
        t_pins();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule